// File: doc/BRIEF.md
# System Control Register Block

A 32-bit memory-mapped register block for a small microcontroller subsystem. It is reached through an APB-style slave port with zero wait states. A transfer takes effect in its access phase, when `psel` and `penable` are both high. Read data is combinational during that phase. Every side effect is registered and appears in the cycle after the access edge.

The block keeps the following state:
- secure-debug bits, with separate set and clear ports;
- a reset cause word, a reset mask and a retention word;
- boot vector addresses that drive the CPU vector outputs;
- per-CPU hold bits, where releasing a bit fires a power-on-and-reset pulse for that CPU;
- plain storage for clock divider, clock force and power sense settings;
- fixed identification bytes.

A static `VARIANT` parameter (A, B or C) decides which offsets exist and how some offsets are reused. The actual clock dividers, power domains and CPUs sit outside the block. Their registers here only store values.

Bits [1:0] of `paddr` are ignored. There is no byte-strobe input: a narrow write arrives as zero-extended data and is stored as a full 32-bit word. The block has a synchronous active-high reset.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the following values hold, and every other register reads 0:

  | Item | Offset | Reset value |
  |------|--------|-------------|
  | Reset cause | 0x100 | 1 |
  | System power sense | 0x200 | 0x7F |
  | Boot vectors | 0x110, 0x114 | `VEC0_RST` / `VEC1_RST`, default 0x10000000 |
  | CPU hold word | — | `WAIT_RST` |
  | Power control (variant C) | 0x1FC | 0x3 |

  No pulse output is active after reset.
- R2: Secure-debug state:
  - Offset 0x000 reads the secure-debug state and is read-only.
  - A write to 0x004 ORs the data into the state.
  - A write to 0x008 clears each bit written as 1.
  - Reads of 0x004 and 0x008 return 0.
- R3: A write to 0x108 with bit 9 set makes `sys_reset_req` high for exactly one cycle after the access. Other bits of that write have no effect. A read of 0x108 returns 0.
- R4: CPU release pulses:
  - A write that turns a stored hold bit i from 1 to 0 makes `cpu_por[i]` high for one cycle after the access.
  - In variants A and B, the hold word is at 0x118 and bits 0 and 1 are active.
  - In variant C, the hold word is at 0x120 and only bit 0 is active.
  - A hold bit that stays 1, stays 0, or goes from 0 to 1 gives no pulse.
- R5: Offset reuse by variant:
  - Variant C: 0x124 is a read/write NMI-enable word, and 0x118 and 0x11C are invalid.
  - Variants A and B: 0x120 is a read/write wake-control word.
  - Variant B: 0x11C is read/write.
  - Variant A: 0x11C reads 0 and is read-only.
- R6: In variant C, bit 0 of the boot vector word at 0x110 is a lock. Once the stored lock bit is 1, writes to 0x110 are refused until reset. In variants A and B, 0x110 never locks.
- R7: In variant C, `boot_vec0` is the stored 0x110 word with bits [6:0] forced to 0. In variants A and B, it is the full stored word. `boot_vec1` is the stored 0x114 word.
- R8: In variant C, a write to 0x1FC is accepted only while the stored bit 0 of 0x1FC is 1. In variants A and B, 0x1FC is invalid.
- R9: Offsets 0xFD0 up to 0xFFC, one word each, read as fixed bytes in address order:
  - 04, 00, 00, 00, 54, B8, 0B, 00, 0D, F0, 05, B1.
  - In variants B and C, the word at 0xFE8 is 1B instead of 0B.
  - These offsets are read-only.
- R10: Which offsets exist depends on the variant:

  | Offsets | Present in |
  |---------|------------|
  | 0x00C, 0x010, 0x014, 0x018 | B, C |
  | 0x200, 0x214, 0x218 | B, C |
  | 0x114 | B |
  | 0x20C, 0x210 | B |
  | 0x204 | C |

- R11: A read of an undefined offset, or of an offset absent from the variant, returns 0. A write to one of them changes no state.
- R12: `access_err` is high for exactly one cycle after any of these accesses, which leave all state unchanged:
  - an access to an invalid offset;
  - a write to a read-only offset;
  - a refused write to a locked 0x110 or 0x1FC.

  A valid access leaves `access_err` low.
- R13: The plain storage words read back the last value written. These are 0x100, 0x104 and 0x10C, the divider and sense words, and the wake, NMI and spare-control words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address, bits [1:0] ignored |
| pwdata | input | 32 | Write data, zero-extended for narrow writes |
| prdata | output | 32 | Read data, valid during a read access phase, else 0 |
| access_err | output | 1 | One-cycle pulse after a refused or invalid access |
| sys_reset_req | output | 1 | One-cycle system reset request |
| cpu_por | output | 2 | One-cycle power-on-and-reset pulse per CPU |
| boot_vec0 | output | 32 | Boot vector of CPU 0 |
| boot_vec1 | output | 32 | Boot vector of CPU 1 |

## Verification
The bench runs one instance of each variant side by side. It targets the offsets whose meaning changes between variants. A design that decoded 0x11C, 0x120 or 0x124 for the wrong variant would read back stored data where 0 or an error is expected, or the reverse.

Release pulses are checked for the exact 1-to-0 case. This includes bit 1 in variant C, which must stay silent. A design that fired on any write of 0, or on every active bit, would show a stray pulse.

The lock bits are exercised by writing through them. A lock tested on the incoming data instead of the stored bit would reject the first locking write. A missing lock would let the following write through and move `boot_vec0`.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

    typedef enum logic [1:0] {
        VAR_A = 2'd0,
        VAR_B = 2'd1,
        VAR_C = 2'd2
    } variant_e;

    localparam int DW        = 32;
    localparam int AW        = 12;
    localparam int NSLOT     = 16;
    localparam int SLOT_W    = $clog2(NSLOT);
    localparam int MAX_CPU   = 2;
    localparam int SWRST_BIT = 9;
    localparam int LOCK_BIT  = 0;
    localparam int VEC_LSB   = 7;
    localparam int ID_WORDS  = 12;
    localparam logic [AW-1:0] ID_BASE = 12'hFD0;

    // what an offset means for the current variant
    typedef enum logic [3:0] {
        K_BAD,
        K_PLAIN,
        K_DBG_STAT,
        K_DBG_SET,
        K_DBG_CLR,
        K_SWRST,
        K_VEC0,
        K_VEC1,
        K_WAIT,
        K_PWR,
        K_ZERO_RO,
        K_ID
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [SLOT_W-1:0] slot;
    } dec_t;

    // plain storage slots
    localparam logic [SLOT_W-1:0] S_SECCTL  = 4'd0;
    localparam logic [SLOT_W-1:0] S_FDIV    = 4'd1;
    localparam logic [SLOT_W-1:0] S_SDIV    = 4'd2;
    localparam logic [SLOT_W-1:0] S_CFORCE  = 4'd3;
    localparam logic [SLOT_W-1:0] S_SYND    = 4'd4;
    localparam logic [SLOT_W-1:0] S_RMASK   = 4'd5;
    localparam logic [SLOT_W-1:0] S_RETAIN  = 4'd6;
    localparam logic [SLOT_W-1:0] S_NMI     = 4'd7;
    localparam logic [SLOT_W-1:0] S_WAKE    = 4'd8;
    localparam logic [SLOT_W-1:0] S_SPARE   = 4'd9;
    localparam logic [SLOT_W-1:0] S_SNS_SYS = 4'd10;
    localparam logic [SLOT_W-1:0] S_SNS_CPU = 4'd11;
    localparam logic [SLOT_W-1:0] S_SNS0    = 4'd12;
    localparam logic [SLOT_W-1:0] S_SNS1    = 4'd13;
    localparam logic [SLOT_W-1:0] S_SNS2    = 4'd14;
    localparam logic [SLOT_W-1:0] S_SNS3    = 4'd15;

    function automatic dec_t plain(input logic [SLOT_W-1:0] s);
        dec_t d;
        d.kind = K_PLAIN;
        d.slot = s;
        return d;
    endfunction

    function automatic dec_t decode_addr(input variant_e v, input logic [AW-1:0] a);
        dec_t d;
        logic [AW-1:0] w;
        w = {a[AW-1:2], 2'b00};
        d.kind = K_BAD;
        d.slot = '0;
        case (w)
            12'h000: d.kind = K_DBG_STAT;
            12'h004: d.kind = K_DBG_SET;
            12'h008: d.kind = K_DBG_CLR;
            12'h00C: if (v != VAR_A) d = plain(S_SECCTL);
            12'h010: if (v != VAR_A) d = plain(S_FDIV);
            12'h014: if (v != VAR_A) d = plain(S_SDIV);
            12'h018: if (v != VAR_A) d = plain(S_CFORCE);
            12'h100: d = plain(S_SYND);
            12'h104: d = plain(S_RMASK);
            12'h108: d.kind = K_SWRST;
            12'h10C: d = plain(S_RETAIN);
            12'h110: d.kind = K_VEC0;
            12'h114: if (v == VAR_B) d.kind = K_VEC1;
            12'h118: if (v != VAR_C) d.kind = K_WAIT;
            12'h11C: begin
                if (v == VAR_A)      d.kind = K_ZERO_RO;
                else if (v == VAR_B) d = plain(S_NMI);
            end
            12'h120: begin
                if (v == VAR_C) d.kind = K_WAIT;
                else            d = plain(S_WAKE);
            end
            12'h124: begin
                if (v == VAR_B)      d = plain(S_SPARE);
                else if (v == VAR_C) d = plain(S_NMI);
            end
            12'h1FC: if (v == VAR_C) d.kind = K_PWR;
            12'h200: if (v != VAR_A) d = plain(S_SNS_SYS);
            12'h204: if (v == VAR_C) d = plain(S_SNS_CPU);
            12'h20C: if (v == VAR_B) d = plain(S_SNS0);
            12'h210: if (v == VAR_B) d = plain(S_SNS1);
            12'h214: if (v != VAR_A) d = plain(S_SNS2);
            12'h218: if (v != VAR_A) d = plain(S_SNS3);
            default: if (w >= ID_BASE) d.kind = K_ID;
        endcase
        return d;
    endfunction

    function automatic logic [7:0] id_byte(input variant_e v, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h54;
            4'd5:    b = 8'hB8;
            4'd6:    b = (v == VAR_A) ? 8'h0B : 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic [DW-1:0] slot_reset(input int i);
        logic [DW-1:0] r;
        if (i == int'(S_SYND))         r = 32'h1;
        else if (i == int'(S_SNS_SYS)) r = 32'h7F;
        else                           r = '0;
        return r;
    endfunction

endpackage

// File: rtl/sysctl_slots.sv
`timescale 1ns/1ps
module sysctl_slots
    import sysctl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [SLOT_W-1:0]          wsel,
    input  logic [DW-1:0]              wdata,
    output logic [NSLOT-1:0][DW-1:0]   q
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= slot_reset(i);
            else if (we && wsel == SLOT_W'(i))
                q[i] <= wdata;
        end
    end

endmodule

// File: rtl/sysctl_cpu.sv
`timescale 1ns/1ps
module sysctl_cpu
    import sysctl_pkg::*;
#(
    parameter variant_e      VARIANT  = VAR_C,
    parameter logic [DW-1:0] WAIT_RST = '0,
    parameter logic [DW-1:0] VEC0_RST = 32'h1000_0000,
    parameter logic [DW-1:0] VEC1_RST = 32'h1000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wait_we,
    input  logic               vec0_we,
    input  logic               vec1_we,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      wait_q,
    output logic [DW-1:0]      vec0_q,
    output logic [DW-1:0]      vec1_q,
    output logic               vec0_locked,
    output logic [MAX_CPU-1:0] cpu_por,
    output logic [DW-1:0]      boot_vec0,
    output logic [DW-1:0]      boot_vec1
);

    localparam int            NCPU     = (VARIANT == VAR_C) ? 1 : 2;
    localparam bit            HAS_LOCK = (VARIANT == VAR_C);
    localparam logic [DW-1:0] VEC_MASK = ~((DW'(1) << VEC_LSB) - DW'(1));

    assign vec0_locked = HAS_LOCK && vec0_q[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= WAIT_RST;
            vec0_q <= VEC0_RST;
            vec1_q <= VEC1_RST;
        end else begin
            if (wait_we)                 wait_q <= wdata;
            if (vec0_we && !vec0_locked) vec0_q <= wdata;
            if (vec1_we)                 vec1_q <= wdata;
        end
    end

    for (genvar i = 0; i < MAX_CPU; i++) begin : g_cpu
        if (i < NCPU) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) cpu_por[i] <= 1'b0;
                else     cpu_por[i] <= wait_we && wait_q[i] && !wdata[i];
            end
        end else begin : g_idle
            assign cpu_por[i] = 1'b0;
        end
    end

    if (HAS_LOCK) begin : g_masked
        assign boot_vec0 = vec0_q & VEC_MASK;
    end else begin : g_full
        assign boot_vec0 = vec0_q;
    end
    assign boot_vec1 = vec1_q;

endmodule

// File: rtl/sysctl_regs.sv
`timescale 1ns/1ps
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter variant_e      VARIANT  = VAR_C,
    parameter logic [DW-1:0] WAIT_RST = '0,
    parameter logic [DW-1:0] VEC0_RST = 32'h1000_0000,
    parameter logic [DW-1:0] VEC1_RST = 32'h1000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [AW-1:0]      paddr,
    input  logic [DW-1:0]      pwdata,
    output logic [DW-1:0]      prdata,
    output logic               access_err,
    output logic               sys_reset_req,
    output logic [MAX_CPU-1:0] cpu_por,
    output logic [DW-1:0]      boot_vec0,
    output logic [DW-1:0]      boot_vec1
);

    localparam logic [DW-1:0] PWR_RST = 32'h3;

    dec_t                     dec;
    logic                     acc, wr, rd, refused, wr_ok;
    logic [DW-1:0]            dbg_q, pwr_q, wait_q, vec0_q, vec1_q;
    logic                     vec0_locked;
    logic [NSLOT-1:0][DW-1:0] slot_q;
    logic [3:0]               id_idx;

    assign dec    = decode_addr(VARIANT, paddr);
    assign acc    = psel && penable;
    assign wr     = acc && pwrite;
    assign rd     = acc && !pwrite;
    assign id_idx = paddr[5:2] - 4'd4;

    always_comb begin
        refused = 1'b0;
        case (dec.kind)
            K_BAD:                      refused = 1'b1;
            K_DBG_STAT, K_ZERO_RO, K_ID: refused = pwrite;
            K_VEC0:                     refused = pwrite && vec0_locked;
            K_PWR:                      refused = pwrite && !pwr_q[0];
            default:                    refused = 1'b0;
        endcase
    end

    assign wr_ok = wr && !refused;

    sysctl_slots u_slots (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && dec.kind == K_PLAIN),
        .wsel  (dec.slot),
        .wdata (pwdata),
        .q     (slot_q)
    );

    sysctl_cpu #(
        .VARIANT  (VARIANT),
        .WAIT_RST (WAIT_RST),
        .VEC0_RST (VEC0_RST),
        .VEC1_RST (VEC1_RST)
    ) u_cpu (
        .clk         (clk),
        .rst         (rst),
        .wait_we     (wr_ok && dec.kind == K_WAIT),
        .vec0_we     (wr_ok && dec.kind == K_VEC0),
        .vec1_we     (wr_ok && dec.kind == K_VEC1),
        .wdata       (pwdata),
        .wait_q      (wait_q),
        .vec0_q      (vec0_q),
        .vec1_q      (vec1_q),
        .vec0_locked (vec0_locked),
        .cpu_por     (cpu_por),
        .boot_vec0   (boot_vec0),
        .boot_vec1   (boot_vec1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_q         <= '0;
            pwr_q         <= PWR_RST;
            sys_reset_req <= 1'b0;
            access_err    <= 1'b0;
        end else begin
            if (wr_ok && dec.kind == K_DBG_SET) dbg_q <= dbg_q | pwdata;
            if (wr_ok && dec.kind == K_DBG_CLR) dbg_q <= dbg_q & ~pwdata;
            if (wr_ok && dec.kind == K_PWR)     pwr_q <= pwdata;
            sys_reset_req <= wr_ok && dec.kind == K_SWRST && pwdata[SWRST_BIT];
            access_err    <= acc && refused;
        end
    end

    always_comb begin
        prdata = '0;
        if (rd) begin
            case (dec.kind)
                K_PLAIN:    prdata = slot_q[dec.slot];
                K_DBG_STAT: prdata = dbg_q;
                K_VEC0:     prdata = vec0_q;
                K_VEC1:     prdata = vec1_q;
                K_WAIT:     prdata = wait_q;
                K_PWR:      prdata = pwr_q;
                K_ID:       prdata = DW'(id_byte(VARIANT, id_idx));
                default:    prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_regs_chk.sv
`timescale 1ns/1ps
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [AW-1:0]      paddr,
    input logic               req_bit,
    input logic [DW-1:0]      prdata,
    input logic               access_err,
    input logic               sys_reset_req,
    input logic [MAX_CPU-1:0] cpu_por,
    input logic [DW-1:0]      boot_vec0
);

    logic acc_wr, acc_rd;
    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;

    a_r3_req_has_cause: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> $past(acc_wr && paddr[AW-1:2] == 10'h042 && req_bit));

    a_r3_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |=> !sys_reset_req);

    a_r4_por_after_write: assert property (@(posedge clk) disable iff (rst)
        (|cpu_por) |-> $past(acc_wr));

    a_r12_err_after_access: assert property (@(posedge clk) disable iff (rst)
        access_err |-> $past(psel && penable));

    a_r2_setclr_read_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && (paddr[AW-1:2] == 10'h001 || paddr[AW-1:2] == 10'h002)) |-> prdata == '0);

    a_r9_last_id_word: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && paddr[AW-1:2] == 10'h3FF) |-> prdata == 32'hB1);

    a_r7_vec_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_wr) |-> $stable(boot_vec0));

endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .psel          (psel),
    .penable       (penable),
    .pwrite        (pwrite),
    .paddr         (paddr),
    .req_bit       (pwdata[9]),
    .prdata        (prdata),
    .access_err    (access_err),
    .sys_reset_req (sys_reset_req),
    .cpu_por       (cpu_por),
    .boot_vec0     (boot_vec0)
);

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
    import sysctl_pkg::*;

    localparam int DC = 0;
    localparam int DA = 1;
    localparam int DB = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  psel = '0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;

    logic [31:0] rd_c, rd_a, rd_b, bv0_c, bv0_a, bv0_b, bv1_c, bv1_a, bv1_b;
    logic [2:0]  err, req;
    logic [1:0]  por_c, por_a, por_b;

    int total = 0;
    int fails = 0;

    logic        err_s, req_s;
    logic [1:0]  por_s;
    logic [31:0] rdata;

    always #10 clk = ~clk;

    sysctl_regs #(.VARIANT(VAR_C), .WAIT_RST(32'h1)) u_dut (
        .clk(clk), .rst(rst), .psel(psel[DC]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd_c), .access_err(err[DC]),
        .sys_reset_req(req[DC]), .cpu_por(por_c), .boot_vec0(bv0_c), .boot_vec1(bv1_c));

    sysctl_regs #(.VARIANT(VAR_A), .WAIT_RST(32'h3)) u_dut_a (
        .clk(clk), .rst(rst), .psel(psel[DA]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd_a), .access_err(err[DA]),
        .sys_reset_req(req[DA]), .cpu_por(por_a), .boot_vec0(bv0_a), .boot_vec1(bv1_a));

    sysctl_regs #(.VARIANT(VAR_B)) u_dut_b (
        .clk(clk), .rst(rst), .psel(psel[DB]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(rd_b), .access_err(err[DB]),
        .sys_reset_req(req[DB]), .cpu_por(por_b), .boot_vec0(bv0_b), .boot_vec1(bv1_b));

    function automatic logic [31:0] pick(input int d, input logic [31:0] c,
                                         input logic [31:0] a, input logic [31:0] b);
        return (d == DC) ? c : ((d == DA) ? a : b);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one APB transfer; pulse outputs are captured in the cycle after the access edge
    task automatic xfer(input int d, input bit w, input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        psel[d] = 1'b1; pwrite = w; paddr = a; pwdata = wd; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 rdata = pick(d, rd_c, rd_a, rd_b);
        @(negedge clk);
        psel = '0; penable = 1'b0; pwrite = 1'b0;
        err_s = err[d];
        req_s = req[d];
        por_s = pick(d, {30'd0, por_c}, {30'd0, por_a}, {30'd0, por_b})[1:0];
    endtask

    task automatic wr(input int d, input logic [11:0] a, input logic [31:0] v);
        xfer(d, 1'b1, a, v);
    endtask

    task automatic rd_chk(input int d, input logic [11:0] a, input logic [31:0] exp,
                          input string tag);
        xfer(d, 1'b0, a, 32'h0);
        chk(tag, rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 vec0 C", bv0_c, 32'h1000_0000);
        chk("R1 vec0 A", bv0_a, 32'h1000_0000);
        chk("R1 vec1 B", bv1_b, 32'h1000_0000);
        chk("R1 pulses", {req, por_c, por_a, por_b}, '0);
        rd_chk(DC, 12'h100, 32'h1, "R1 syndrome");
        rd_chk(DC, 12'h200, 32'h7F, "R1 sys sense");
        rd_chk(DC, 12'h1FC, 32'h3, "R1 power ctl");
        rd_chk(DC, 12'h120, 32'h1, "R1 wait C");
        rd_chk(DA, 12'h118, 32'h3, "R1 wait A");
        rd_chk(DB, 12'h118, 32'h0, "R1 wait B");
        rd_chk(DB, 12'h114, 32'h1000_0000, "R1 vec1 read");
        rd_chk(DA, 12'h10C, 32'h0, "R1 retain");
        rd_chk(DC, 12'h000, 32'h0, "R1 dbg");
    endtask

    task automatic t_secdbg;
        wr(DC, 12'h004, 32'h0000_00F0);
        rd_chk(DC, 12'h000, 32'h0000_00F0, "R2 set");
        wr(DC, 12'h004, 32'h0000_0003);
        rd_chk(DC, 12'h000, 32'h0000_00F3, "R2 or");
        wr(DC, 12'h008, 32'h0000_0030);
        rd_chk(DC, 12'h000, 32'h0000_00C3, "R2 clear");
        rd_chk(DC, 12'h004, 32'h0, "R2 set reads zero");
        rd_chk(DC, 12'h008, 32'h0, "R2 clr reads zero");
        wr(DC, 12'h000, 32'hFFFF_FFFF);
        chk("R2 ro write err", {31'd0, err_s}, 32'h1);
        rd_chk(DC, 12'h000, 32'h0000_00C3, "R2 ro unchanged");
    endtask

    task automatic t_swreset;
        wr(DA, 12'h108, 32'h0000_0200);
        chk("R3 pulse", {31'd0, req_s}, 32'h1);
        @(negedge clk);
        chk("R3 pulse one cycle", {31'd0, req[DA]}, 32'h0);
        wr(DA, 12'h108, 32'hFFFF_FDFF);
        chk("R3 other bits", {31'd0, req_s}, 32'h0);
        rd_chk(DA, 12'h108, 32'h0, "R3 read zero");
    endtask

    task automatic t_release;
        wr(DA, 12'h118, 32'h1);
        chk("R4 A cpu1", {30'd0, por_s}, 32'h2);
        @(negedge clk);
        chk("R4 A one cycle", {30'd0, por_a}, 32'h0);
        wr(DA, 12'h118, 32'h0);
        chk("R4 A cpu0", {30'd0, por_s}, 32'h1);
        wr(DA, 12'h118, 32'h3);
        chk("R4 A rise silent", {30'd0, por_s}, 32'h0);
        rd_chk(DA, 12'h118, 32'h3, "R4 A readback");
        wr(DC, 12'h120, 32'h2);
        chk("R4 C cpu0", {30'd0, por_s}, 32'h1);
        wr(DC, 12'h120, 32'h0);
        chk("R4 C bit1 silent", {30'd0, por_s}, 32'h0);
        wr(DB, 12'h118, 32'h0);
        chk("R4 B zero to zero", {30'd0, por_s}, 32'h0);
    endtask

    task automatic t_reuse;
        wr(DC, 12'h124, 32'h5);
        rd_chk(DC, 12'h124, 32'h5, "R5 C nmi");
        rd_chk(DC, 12'h118, 32'h0, "R5 C 118 zero");
        chk("R5 C 118 err", {31'd0, err_s}, 32'h1);
        wr(DC, 12'h11C, 32'h7);
        chk("R5 C 11C err", {31'd0, err_s}, 32'h1);
        wr(DB, 12'h120, 32'hA);
        rd_chk(DB, 12'h120, 32'hA, "R5 B wake");
        wr(DB, 12'h11C, 32'h1);
        rd_chk(DB, 12'h11C, 32'h1, "R5 B 11C");
        wr(DA, 12'h120, 32'h6);
        rd_chk(DA, 12'h120, 32'h6, "R5 A wake");
        wr(DA, 12'h11C, 32'h7);
        chk("R5 A 11C ro err", {31'd0, err_s}, 32'h1);
        rd_chk(DA, 12'h11C, 32'h0, "R5 A 11C zero");
        chk("R5 A 11C read ok", {31'd0, err_s}, 32'h0);
    endtask

    task automatic t_lock;
        wr(DC, 12'h110, 32'h2000_00FF);
        chk("R6 locking write ok", {31'd0, err_s}, 32'h0);
        chk("R7 C masked vec", bv0_c, 32'h2000_0080);
        rd_chk(DC, 12'h110, 32'h2000_00FF, "R6 stored");
        wr(DC, 12'h110, 32'h3000_0000);
        chk("R6 locked err", {31'd0, err_s}, 32'h1);
        @(negedge clk);
        chk("R12 err one cycle", {31'd0, err[DC]}, 32'h0);
        chk("R6 vec held", bv0_c, 32'h2000_0080);
        rd_chk(DC, 12'h110, 32'h2000_00FF, "R6 read held");
        wr(DA, 12'h110, 32'h1234_567F);
        chk("R7 A full vec", bv0_a, 32'h1234_567F);
        wr(DA, 12'h110, 32'h0000_0011);
        chk("R6 A no lock", bv0_a, 32'h0000_0011);
        wr(DB, 12'h114, 32'hABCD_0000);
        chk("R7 B vec1", bv1_b, 32'hABCD_0000);
    endtask

    task automatic t_pwr;
        wr(DC, 12'h1FC, 32'h2);
        chk("R8 unlocked ok", {31'd0, err_s}, 32'h0);
        rd_chk(DC, 12'h1FC, 32'h2, "R8 write taken");
        wr(DC, 12'h1FC, 32'h3);
        chk("R8 locked err", {31'd0, err_s}, 32'h1);
        rd_chk(DC, 12'h1FC, 32'h2, "R8 write refused");
        rd_chk(DA, 12'h1FC, 32'h0, "R8 A absent");
        chk("R8 A err", {31'd0, err_s}, 32'h1);
    endtask

    function automatic logic [31:0] id_exp(input bit var_a, input int i);
        logic [7:0] t [12];
        t = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8, 8'h0B, 8'h00,
              8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (!var_a && i == 6) return 32'h1B;
        return {24'd0, t[i]};
    endfunction

    task automatic t_id;
        for (int i = 0; i < 12; i++)
            rd_chk(DA, 12'hFD0 + 12'(i * 4), id_exp(1'b1, i), "R9 id A");
        rd_chk(DB, 12'hFE8, id_exp(1'b0, 6), "R9 id B");
        rd_chk(DC, 12'hFE8, id_exp(1'b0, 6), "R9 id C");
        wr(DB, 12'hFE0, 32'hFF);
        chk("R9 id ro err", {31'd0, err_s}, 32'h1);
        rd_chk(DB, 12'hFE0, 32'h54, "R9 id unchanged");
    endtask

    task automatic t_presence;
        wr(DA, 12'h010, 32'h55);
        chk("R10 A div err", {31'd0, err_s}, 32'h1);
        rd_chk(DA, 12'h010, 32'h0, "R10 A div zero");
        wr(DB, 12'h010, 32'h55);
        rd_chk(DB, 12'h010, 32'h55, "R10 B div");
        rd_chk(DB, 12'h204, 32'h0, "R10 B 204");
        chk("R10 B 204 err", {31'd0, err_s}, 32'h1);
        wr(DC, 12'h204, 32'h9);
        rd_chk(DC, 12'h204, 32'h9, "R10 C 204");
        wr(DB, 12'h20C, 32'h44);
        rd_chk(DB, 12'h20C, 32'h44, "R10 B 20C");
        wr(DC, 12'h214, 32'h66);
        wr(DC, 12'h20C, 32'h77);
        chk("R10 C 20C err", {31'd0, err_s}, 32'h1);
        rd_chk(DC, 12'h214, 32'h66, "R11 neighbour unchanged");
        rd_chk(DC, 12'h114, 32'h0, "R10 C 114");
        chk("R10 C 114 err", {31'd0, err_s}, 32'h1);
        rd_chk(DC, 12'h300, 32'h0, "R11 undefined read");
        chk("R12 undefined err", {31'd0, err_s}, 32'h1);
    endtask

    task automatic t_plain;
        wr(DA, 12'h10C, 32'hDEAD_BEEF);
        chk("R12 valid no err", {31'd0, err_s}, 32'h0);
        rd_chk(DA, 12'h10C, 32'hDEAD_BEEF, "R13 retain");
        wr(DA, 12'h104, 32'h0000_A5A5);
        rd_chk(DA, 12'h104, 32'h0000_A5A5, "R13 mask");
        wr(DA, 12'h100, 32'h0);
        rd_chk(DA, 12'h100, 32'h0, "R13 syndrome");
        wr(DB, 12'h018, 32'h1357_9BDF);
        rd_chk(DB, 12'h018, 32'h1357_9BDF, "R13 force");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_secdbg;
        t_swreset;
        t_release;
        t_reuse;
        t_lock;
        t_pwr;
        t_id;
        t_presence;
        t_plain;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule